// File: doc/BRIEF.md
# Falling-Edge Manchester Frame Decoder

This block rebuilds a bit frame sent by a tag as Manchester-coded load modulation. It looks only at the spacing between falling edges of an envelope signal that has already been synchronised. The spacing is counted in carrier periods: a tick input pulses once per period. The length of each gap is compared with multiples of a half bit period. That result, together with a last-bit register and a skip toggle, decides which bits are appended. A programmable number of start-of-frame bits is consumed before anything is stored. The bits are packed first-bit-first into a frame vector. The first long gap after the window opens gives the response delay of the tag.

A receive window opens when `arm` is pulsed while the block is idle. The frame ends in one of two ways. If at least one bit has been stored, the frame ends after a silence of 80 periods. If nothing has been stored, it ends after 300 periods without a falling edge. The end is marked by a one-clock `frame_done` pulse. After that, the frame, the count and the delay hold until the next `arm`.

The controller has three states:
- `ST_IDLE`: waits for `arm` and moves to `ST_LISTEN`.
- `ST_LISTEN`: classifies each falling edge. It moves to `ST_FINISH` on the silence limit or on the window limit.
- `ST_FINISH`: raises `frame_done` for one clock and returns to `ST_IDLE` unconditionally.

Top module: `mdec_frame_rx`

## Requirements
- R1: After reset, `frame_bits`, `bit_count` and `resp_delay` are zero and `frame_done` is low. A pulse on `arm` while idle clears all three again.
- R2: A falling-edge gap of 80 periods or more stores no bit and sets `resp_delay` to the gap minus 16.
- R3: A gap of 25 to 40 periods appends nothing while the start-of-frame counter is non-zero, and decrements that counter instead. The counter is loaded at `arm` with 4 when `long_sof`=1 and with 1 when `long_sof`=0.
- R4: Once the start-of-frame counter is zero, a gap of 25 to 40 periods appends one copy of the last-bit register. That register is 1 at the start of every frame.
- R5: A gap of 41 to 56 periods appends a 0, followed by a 1 only when the skip toggle is clear, and then inverts both the last-bit register and the skip toggle. The skip toggle is set at the start of every frame.
- R6: A gap of 57 to 79 periods appends 0 then 1 and leaves the last-bit register unchanged.
- R7: A gap under 25 periods appends nothing and changes no decode state, but still restarts the gap measurement.
- R8: Bits are packed first-bit-first: the n-th stored bit (counting from 0) sits at `frame_bits[MAX_BITS-1-n]`, and bit positions not yet written read 0.
- R9: With `bit_count` > 0, 80 periods without a falling edge end the frame with a `frame_done` pulse.
- R10: With no bit stored, 300 periods without a falling edge end the frame with `bit_count` = 0.
- R11: `frame_done` lasts exactly one clock. Outside the receive window, falling edges change none of the outputs.
- R12: `bit_count` saturates at `MAX_BITS`, and further bits are dropped.
- R13: Every `arm` restores the last-bit register, the skip toggle and the start-of-frame counter, whatever the previous frame left in them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| env_in | input | 1 | Synchronised envelope level |
| tick | input | 1 | One-clock pulse per carrier period |
| arm | input | 1 | Opens a receive window when idle |
| long_sof | input | 1 | 1: discard 4 start bits, 0: discard 1 |
| frame_bits | output | MAX_BITS | Decoded bits, first bit at the top |
| bit_count | output | $clog2(MAX_BITS+1) | Number of stored bits |
| frame_done | output | 1 | One-clock end-of-frame strobe |
| resp_delay | output | $clog2(T_WINDOW+1) | Leading gap minus half a bit period |

## Verification
Each gap class is driven at both of its edges (24/25, 40/41, 56/57, 79), and both start-of-frame lengths are used. These cases expose a wrong threshold comparison or a swapped discard count through a change in `bit_count`.

Mixed sequences of toggles, repeats and pairs check the interplay of the last-bit register and the skip toggle. This catches errors that a stream of repeats alone would not. A frame that leaves both registers inverted, followed by a fresh frame, shows whether `arm` restores them.

The silent window, the silence limit after data, a frame longer than the buffer, and edges outside the window cover the ending and holding behaviour.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LISTEN,
        ST_FINISH
    } rx_state_e;

    typedef enum logic [2:0] {
        GAP_IGNORE,
        GAP_REPEAT,
        GAP_TOGGLE,
        GAP_PAIR,
        GAP_LEAD
    } gap_kind_e;

endpackage

// File: rtl/mdec_gap_timer.sv
module mdec_gap_timer #(
    parameter int T_WINDOW = 300,
    parameter int GW       = $clog2(T_WINDOW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic          env_in,
    output logic          fall_o,
    output logic [GW-1:0] gap_o
);

    localparam logic [GW-1:0] GAP_CAP = GW'(T_WINDOW);

    logic          env_d;
    logic [GW-1:0] cnt_q;

    assign fall_o = env_d & ~env_in;
    assign gap_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            env_d <= 1'b1;
            cnt_q <= '0;
        end else begin
            env_d <= env_in;
            if (restart || fall_o) begin
                cnt_q <= '0;
            end else if (tick && cnt_q != GAP_CAP) begin
                cnt_q <= cnt_q + GW'(1);
            end
        end
    end

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= GAP_CAP); // R10

endmodule

// File: rtl/mdec_gap_class.sv
module mdec_gap_class
    import mdec_pkg::*;
#(
    parameter int GW           = 9,
    parameter int T_REPEAT_MIN = 25,
    parameter int T_TOGGLE_MIN = 41,
    parameter int T_PAIR_MIN   = 57,
    parameter int T_LEAD_MIN   = 80
) (
    input  logic [GW-1:0] gap_i,
    output gap_kind_e     kind_o
);

    localparam logic [GW-1:0] TH_REPEAT = GW'(T_REPEAT_MIN);
    localparam logic [GW-1:0] TH_TOGGLE = GW'(T_TOGGLE_MIN);
    localparam logic [GW-1:0] TH_PAIR   = GW'(T_PAIR_MIN);
    localparam logic [GW-1:0] TH_LEAD   = GW'(T_LEAD_MIN);

    always_comb begin
        if (gap_i >= TH_LEAD)        kind_o = GAP_LEAD;
        else if (gap_i >= TH_PAIR)   kind_o = GAP_PAIR;
        else if (gap_i >= TH_TOGGLE) kind_o = GAP_TOGGLE;
        else if (gap_i >= TH_REPEAT) kind_o = GAP_REPEAT;
        else                         kind_o = GAP_IGNORE;
    end

endmodule

// File: rtl/mdec_bit_pack.sv
module mdec_bit_pack #(
    parameter int MAX_BITS = 64,
    parameter int CW       = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [1:0]          add_n,
    input  logic                bit_a,
    input  logic                bit_b,
    output logic [MAX_BITS-1:0] frame_o,
    output logic [CW-1:0]       count_o
);

    logic [MAX_BITS-1:0] frame_q, frame_nx;
    logic [CW-1:0]       count_q, count_nx;
    int                  sum;

    always_comb begin
        frame_nx = frame_q;
        for (int i = 0; i < MAX_BITS; i++) begin
            if (add_n != 2'd0 && int'(count_q) == i)
                frame_nx[MAX_BITS-1-i] = bit_a;
            if (add_n == 2'd2 && int'(count_q) + 1 == i)
                frame_nx[MAX_BITS-1-i] = bit_b;
        end
        sum      = int'(count_q) + int'(add_n);
        count_nx = (sum > MAX_BITS) ? CW'(MAX_BITS) : CW'(sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            count_q <= '0;
        end else if (clear) begin
            frame_q <= '0;
            count_q <= '0;
        end else begin
            frame_q <= frame_nx;
            count_q <= count_nx;
        end
    end

    assign frame_o = frame_q;
    assign count_o = count_q;

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(MAX_BITS)); // R12
    AST_ADD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        add_n != 2'd3); // R6

endmodule

// File: rtl/mdec_frame_rx.sv
module mdec_frame_rx
    import mdec_pkg::*;
#(
    parameter int MAX_BITS     = 64,
    parameter int T_HALF       = 16,
    parameter int T_REPEAT_MIN = 25,
    parameter int T_TOGGLE_MIN = 41,
    parameter int T_PAIR_MIN   = 57,
    parameter int T_LEAD_MIN   = 80,
    parameter int T_EOF        = 80,
    parameter int T_WINDOW     = 300,
    parameter int SOF_LONG     = 4,
    parameter int SOF_SHORT    = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             env_in,
    input  logic                             tick,
    input  logic                             arm,
    input  logic                             long_sof,
    output logic [MAX_BITS-1:0]              frame_bits,
    output logic [$clog2(MAX_BITS+1)-1:0]    bit_count,
    output logic                             frame_done,
    output logic [$clog2(T_WINDOW+1)-1:0]    resp_delay
);

    localparam int GW      = $clog2(T_WINDOW + 1);
    localparam int CW      = $clog2(MAX_BITS + 1);
    localparam int SOF_MAX = (SOF_LONG > SOF_SHORT) ? SOF_LONG : SOF_SHORT;
    localparam int SW      = $clog2(SOF_MAX + 1);
    localparam logic [GW-1:0] G_EOF  = GW'(T_EOF);
    localparam logic [GW-1:0] G_WIN  = GW'(T_WINDOW);
    localparam logic [GW-1:0] G_HALF = GW'(T_HALF);

    rx_state_e     state_q, state_d;
    gap_kind_e     kind;
    logic          fall;
    logic [GW-1:0] gap_now;
    logic          lastbit_q, skip_q;
    logic [SW-1:0] sof_q;
    logic [GW-1:0] resp_q;
    logic [CW-1:0] count_w;
    logic [MAX_BITS-1:0] frame_w;
    logic [1:0]    add_n;
    logic          bit_a, bit_b;
    logic          arm_go, take, end_hit;

    assign arm_go  = (state_q == ST_IDLE) && arm;
    assign take    = (state_q == ST_LISTEN) && fall;
    assign end_hit = (state_q == ST_LISTEN) && !fall &&
                     (((count_w != '0) && (gap_now >= G_EOF)) || (gap_now == G_WIN));

    mdec_gap_timer #(.T_WINDOW(T_WINDOW), .GW(GW)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(arm_go),
        .tick   (tick),
        .env_in (env_in),
        .fall_o (fall),
        .gap_o  (gap_now)
    );

    mdec_gap_class #(
        .GW(GW), .T_REPEAT_MIN(T_REPEAT_MIN), .T_TOGGLE_MIN(T_TOGGLE_MIN),
        .T_PAIR_MIN(T_PAIR_MIN), .T_LEAD_MIN(T_LEAD_MIN)
    ) class_i (
        .gap_i (gap_now),
        .kind_o(kind)
    );

    mdec_bit_pack #(.MAX_BITS(MAX_BITS), .CW(CW)) pack_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (arm_go),
        .add_n  (add_n),
        .bit_a  (bit_a),
        .bit_b  (bit_b),
        .frame_o(frame_w),
        .count_o(count_w)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (arm) state_d = ST_LISTEN;
            ST_LISTEN: if (end_hit) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Bits appended for the current falling edge
    always_comb begin
        add_n = 2'd0;
        bit_a = 1'b0;
        bit_b = 1'b0;
        if (take) begin
            unique case (kind)
                GAP_PAIR: begin
                    add_n = 2'd2;
                    bit_b = 1'b1;
                end
                GAP_TOGGLE: begin
                    add_n = skip_q ? 2'd1 : 2'd2;
                    bit_b = 1'b1;
                end
                GAP_REPEAT: begin
                    if (sof_q == '0) begin
                        add_n = 2'd1;
                        bit_a = lastbit_q;
                    end
                end
                default: add_n = 2'd0;
            endcase
        end
    end

    // Decode state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lastbit_q <= 1'b1;
            skip_q    <= 1'b1;
            sof_q     <= SW'(SOF_SHORT);
            resp_q    <= '0;
        end else if (arm_go) begin
            lastbit_q <= 1'b1;
            skip_q    <= 1'b1;
            sof_q     <= long_sof ? SW'(SOF_LONG) : SW'(SOF_SHORT);
            resp_q    <= '0;
        end else if (take) begin
            unique case (kind)
                GAP_LEAD:   resp_q <= gap_now - G_HALF;
                GAP_TOGGLE: begin
                    lastbit_q <= ~lastbit_q;
                    skip_q    <= ~skip_q;
                end
                GAP_REPEAT: if (sof_q != '0) sof_q <= sof_q - SW'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        frame_done = (state_q == ST_FINISH);
        frame_bits = frame_w;
        bit_count  = count_w;
        resp_delay = resp_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !arm) |=>
        ($stable(bit_count) && $stable(frame_bits) && $stable(resp_delay))); // R11
    AST_LEAD_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == GAP_LEAD) |=> $stable(bit_count)); // R2
    AST_LISTEN_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LISTEN) |=> (bit_count >= $past(bit_count))); // R4

endmodule

// File: tb/mdec_frame_rx_tb_top.sv
module mdec_frame_rx_tb_top;

    localparam int MB = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          env_in = 1'b1;
    logic          tick = 1'b0;
    logic          arm = 1'b0;
    logic          long_sof = 1'b0;
    logic [MB-1:0] frame_bits;
    logic [6:0]    bit_count;
    logic          frame_done;
    logic [8:0]    resp_delay;

    int n_chk = 0;
    int n_bad = 0;
    int tdiv = 0;
    int ticks_seen = 0;
    int mark_ticks = 0;
    int done_ticks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mdec_frame_rx dut_i (
        .clk(clk), .rst_n(rst_n), .env_in(env_in), .tick(tick), .arm(arm),
        .long_sof(long_sof), .frame_bits(frame_bits), .bit_count(bit_count),
        .frame_done(frame_done), .resp_delay(resp_delay)
    );

    always @(negedge clk) begin
        tdiv = (tdiv + 1) % 4;
        tick = (tdiv == 0);
    end

    always @(posedge clk) if (tick && rst_n) ticks_seen <= ticks_seen + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_frame(input logic lng);
        int tgt;
        tgt = ticks_seen + 1;
        wait (ticks_seen >= tgt);
        @(negedge clk);
        arm = 1'b1;
        long_sof = lng;
        @(negedge clk);
        arm = 1'b0;
        mark_ticks = ticks_seen;
    endtask

    task automatic fall_gap(input int n);
        int tgt;
        tgt = ticks_seen + n;
        wait (ticks_seen >= tgt);
        @(negedge clk);
        env_in = 1'b0;
        @(negedge clk);
        env_in = 1'b1;
        mark_ticks = ticks_seen;
    endtask

    task automatic wait_done(input string req);
        int k;
        k = 0;
        while (!frame_done && k < 4000) begin
            @(negedge clk);
            k++;
        end
        chk(req, {63'd0, frame_done}, 64'd1);
        done_ticks = ticks_seen;
        @(negedge clk);
        chk("R11 done one clock", {63'd0, frame_done}, 64'd0);
    endtask

    task automatic t_reset;
        chk("R1 reset count", 64'(bit_count), 64'd0);
        chk("R1 reset frame", frame_bits, 64'd0);
        chk("R1 reset resp", 64'(resp_delay), 64'd0);
        chk("R1 reset done", {63'd0, frame_done}, 64'd0);
    endtask

    task automatic t_long_sof;
        start_frame(1'b1);
        fall_gap(100);
        repeat (7) fall_gap(32);
        wait_done("R9 done after data");
        chk("R9 silence length", 64'(done_ticks - mark_ticks), 64'd80);
        chk("R3 long sof count", 64'(bit_count), 64'd3);
        chk("R4 repeat ones", frame_bits, 64'hE000_0000_0000_0000);
        chk("R2 resp 100-16", 64'(resp_delay), 64'd84);
    endtask

    task automatic t_mixed;
        start_frame(1'b0);
        fall_gap(90);
        fall_gap(32); fall_gap(32); fall_gap(48); fall_gap(32);
        fall_gap(48); fall_gap(32); fall_gap(64);
        wait_done("R9 mixed done");
        chk("R5 mixed count", 64'(bit_count), 64'd8);
        chk("R8 mixed frame", frame_bits, 64'h8D00_0000_0000_0000);
        chk("R2 resp 90-16", 64'(resp_delay), 64'd74);
    endtask

    task automatic t_ignore;
        start_frame(1'b0);
        fall_gap(90);
        fall_gap(10); fall_gap(20); fall_gap(32); fall_gap(32);
        wait_done("R7 done");
        chk("R7 short gaps ignored", 64'(bit_count), 64'd1);
        chk("R7 frame", frame_bits, 64'h8000_0000_0000_0000);
    endtask

    task automatic t_bounds;
        start_frame(1'b0);
        fall_gap(90);
        fall_gap(25); fall_gap(25); fall_gap(24); fall_gap(40);
        fall_gap(41); fall_gap(56); fall_gap(57); fall_gap(79);
        wait_done("R6 bounds done");
        chk("R6 bounds count", 64'(bit_count), 64'd9);
        chk("R5 bounds frame", frame_bits, 64'hCA80_0000_0000_0000);
    endtask

    task automatic t_timeout;
        start_frame(1'b1);
        wait_done("R10 empty window done");
        chk("R10 window length", 64'(done_ticks - mark_ticks), 64'd300);
        chk("R10 empty count", 64'(bit_count), 64'd0);
        chk("R10 empty resp", 64'(resp_delay), 64'd0);
    endtask

    task automatic t_rearm;
        start_frame(1'b0);
        fall_gap(90); fall_gap(32); fall_gap(48);
        wait_done("R13 first done");
        chk("R13 first count", 64'(bit_count), 64'd1);
        fall_gap(32); fall_gap(32); fall_gap(60);
        repeat (4) @(negedge clk);
        chk("R11 idle edges count", 64'(bit_count), 64'd1);
        chk("R11 idle edges frame", frame_bits, 64'd0);
        chk("R11 idle edges resp", 64'(resp_delay), 64'd74);
        start_frame(1'b0);
        chk("R1 arm clears resp", 64'(resp_delay), 64'd0);
        fall_gap(100); fall_gap(32); fall_gap(32); fall_gap(48);
        wait_done("R13 second done");
        chk("R13 restored count", 64'(bit_count), 64'd2);
        chk("R13 restored frame", frame_bits, 64'h8000_0000_0000_0000);
        chk("R2 second resp", 64'(resp_delay), 64'd84);
    endtask

    task automatic t_saturate;
        start_frame(1'b0);
        fall_gap(90);
        repeat (67) fall_gap(32);
        wait_done("R12 done");
        chk("R12 count saturates", 64'(bit_count), 64'd64);
        chk("R12 frame full", frame_bits, {64{1'b1}});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long_sof();
        t_mixed();
        t_ignore();
        t_bounds();
        t_timeout();
        t_rearm();
        t_saturate();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule